// File: doc/BRIEF.md
# Calibrating Clock Divider with Pulse Inhibition

This block sits right after the crystal oscillator of a timekeeping circuit. Each cycle of its clock is one period of the 32768 Hz oscillator. It divides that clock down to three single-cycle tick enables: a fast tick at 8192 Hz, a mid tick at 32 Hz and a slow tick at 1 Hz. It also provides a 32 Hz square wave, which is the oscillator divided by 1024. The rest of the timekeeping logic runs from these enables.

The crystal usually runs slightly fast, so the block applies a digital rate trim. At the end of each calibration window it drops a programmed number of fast ticks, from 0 to 127. The window lasts one minute or two minutes, chosen by a select bit. While these ticks are dropped, every stage below the prescaler is frozen. Each dropped tick therefore holds back the whole time base by one fast-tick period, about 0.122 ms.

A separate measurement output makes the programmed trim visible on a frequency counter. It is a square wave whose period is the nominal 31.25 ms plus the trim count times one fast-tick period. The count and the select bit are sampled only at the start of each window, and a frame of the measurement wave samples the count at its own start.

Top module: `calib_divider`

## Requirements
- R1: A synchronous reset clears every divider stage and the window counter, and it samples `trimCount` and `windowSel`. While reset is held, `tick8k`, `tick32`, `tick1` and `sq32` are low and `measWave` is high. After release, the first `tick1` is seen once PRE_DIV*MID_DIV*LOW_DIV-1 clock edges have passed.
- R2: With no trim pending, `tick8k` pulses every PRE_DIV clocks. `tick32` pulses on every MID_DIV-th `tick8k`, and `tick1` pulses on every LOW_DIV-th `tick32`.
- R3: `sq32` is high while the mid stage is in the upper half of its count. Its period is PRE_DIV*MID_DIV clocks when no trim falls inside it, so its first rise comes PRE_DIV*MID_DIV/2 edges after release.
- R4: After the `tick1` that closes a window, the next n slots of the prescaler produce no `tick8k`, where n is the trim count in force for that window. That gap between `tick1` pulses therefore grows by PRE_DIV*n clocks.
- R5: With `windowSel`=0, a window spans SEC_PER_MIN `tick1` pulses. With `windowSel`=1, it spans 2*SEC_PER_MIN pulses.
- R6: `trimCount` and `windowSel` take effect only when sampled, at reset or at the `tick1` that closes a window. A change between those points has no effect on the window in progress.
- R7: `trimCount` is an unsigned binary value with bit 6 as MSB. A value of 0 leaves the gap at its nominal length, and 127 gives the longest trim.
- R8: `measWave` repeats every PRE_DIV*MID_DIV + PRE_DIV*n clocks. It is high for the first PRE_DIV*MID_DIV/2 clocks of each frame, and n is sampled at each frame start.
- R9: Exactly MID_DIV*LOW_DIV `tick8k` pulses occur from one `tick1` up to and including the next, whether or not a trim lies between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | oscillator clock, one cycle per 32768 Hz period |
| rst | input | 1 | synchronous reset, active high |
| trimCount | input | 7 | number of fast ticks to drop per window, bit 6 MSB |
| windowSel | input | 1 | window length select: 0 = one minute, 1 = two minutes |
| tick8k | output | 1 | fast tick enable (8192 Hz nominal) |
| tick32 | output | 1 | mid tick enable (32 Hz nominal) |
| tick1 | output | 1 | slow tick enable (1 Hz nominal) |
| sq32 | output | 1 | 32 Hz square wave, oscillator divided by 1024 |
| measWave | output | 1 | trim measurement wave, period stretched by the trim |

## Verification
The assertions rely on two conditions. The trim burst must end before the next window closes. The measurement frame must be at least two clocks in its high phase. Both follow from the divider ratios, as long as PRE_DIV*MID_DIV is at least 4 and the window holds at least one full slow tick. The bench reduces MID_DIV, LOW_DIV and SEC_PER_MIN to small values that keep both conditions. It changes the inputs only at reset release or in the middle of a window, so every sampling point it checks lies at a known cycle.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
  // strobes from the control half to the counting half
  typedef struct packed {
    logic step8k;   // gated fast tick
    logic inBurst;  // trim burst in progress
  } cdivStrobe_t;
endpackage

// File: rtl/cdiv_ctrl.sv
`timescale 1ns/1ps
module cdiv_ctrl
  import cdiv_pkg::*;
#(
  parameter int PRE_DIV     = 4,
  parameter int SEC_PER_MIN = 60,
  parameter int INH_W       = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INH_W-1:0] trimIn,
  input  logic             selIn,
  input  logic             tick1,
  output cdivStrobe_t      strobe
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int SEC_W = $clog2(2 * SEC_PER_MIN);
  localparam logic [PRE_W-1:0] PRE_LAST   = PRE_W'(PRE_DIV - 1);
  localparam logic [SEC_W-1:0] SHORT_LAST = SEC_W'(SEC_PER_MIN - 1);
  localparam logic [SEC_W-1:0] LONG_LAST  = SEC_W'(2 * SEC_PER_MIN - 1);

  logic [PRE_W-1:0] preCnt;
  logic [INH_W-1:0] burstCnt;
  logic [INH_W-1:0] trimLatched;
  logic             selLatched;
  logic [SEC_W-1:0] secCnt;
  logic             rawTick;
  logic             burstActive;
  logic [SEC_W-1:0] lastSec;
  logic             windowEnd;

  always_comb begin
    rawTick     = (preCnt == PRE_LAST);
    burstActive = (burstCnt != '0);
    lastSec     = selLatched ? LONG_LAST : SHORT_LAST;
    windowEnd   = tick1 && (secCnt == lastSec);
    strobe.step8k  = rawTick && !burstActive;
    strobe.inBurst = burstActive;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt      <= '0;
      burstCnt    <= '0;
      secCnt      <= '0;
      trimLatched <= trimIn;
      selLatched  <= selIn;
    end else begin
      preCnt <= rawTick ? '0 : preCnt + 1'b1;
      if (rawTick && burstActive)
        burstCnt <= burstCnt - 1'b1;
      if (windowEnd) begin
        burstCnt    <= trimLatched;
        trimLatched <= trimIn;
        selLatched  <= selIn;
        secCnt      <= '0;
      end else if (tick1) begin
        secCnt <= secCnt + 1'b1;
      end
    end
  end

  // R4: each swallowed slot takes exactly one off the burst
  a_r4_burst_count_down: assert property (@(posedge clk) disable iff (rst)
    (rawTick && burstActive && !windowEnd) |=> burstCnt == $past(burstCnt) - 1'b1);

  // R6: sampled calibration inputs hold between window ends
  a_r6_hold_between_windows: assert property (@(posedge clk) disable iff (rst)
    !windowEnd |=> ($stable(trimLatched) && $stable(selLatched)));

  // R5: slow-tick count never passes the window length
  a_r5_sec_in_range: assert property (@(posedge clk) disable iff (rst)
    secCnt <= lastSec);

  // R4: a burst is finished before the slow tick that closes the next window
  a_r4_burst_done_by_end: assert property (@(posedge clk) disable iff (rst)
    tick1 |-> !burstActive);
endmodule

// File: rtl/cdiv_dp.sv
`timescale 1ns/1ps
module cdiv_dp
  import cdiv_pkg::*;
#(
  parameter int MID_DIV = 256,
  parameter int LOW_DIV = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  cdivStrobe_t strobe,
  output logic        tick8k,
  output logic        tick32,
  output logic        tick1,
  output logic        sq32
);
  localparam int MID_W = $clog2(MID_DIV);
  localparam int LOW_W = (LOW_DIV > 1) ? $clog2(LOW_DIV) : 1;
  localparam logic [MID_W-1:0] MID_LAST = MID_W'(MID_DIV - 1);
  localparam logic [MID_W-1:0] MID_HALF = MID_W'(MID_DIV / 2);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(LOW_DIV - 1);

  logic [MID_W-1:0] midCnt;
  logic [LOW_W-1:0] lowCnt;

  always_comb begin
    tick8k = strobe.step8k;
    tick32 = strobe.step8k && (midCnt == MID_LAST);
    tick1  = tick32 && (lowCnt == LOW_LAST);
    sq32   = (midCnt >= MID_HALF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      midCnt <= '0;
      lowCnt <= '0;
    end else if (strobe.step8k) begin
      midCnt <= (midCnt == MID_LAST) ? '0 : midCnt + 1'b1;
      if (midCnt == MID_LAST)
        lowCnt <= (lowCnt == LOW_LAST) ? '0 : lowCnt + 1'b1;
    end
  end

  // R9: lower stages are frozen whenever no fast tick is passed on
  a_r9_frozen_without_step: assert property (@(posedge clk) disable iff (rst)
    !strobe.step8k |=> ($stable(midCnt) && $stable(lowCnt)));

  // R4: no mid tick can be issued during a trim burst
  a_r4_quiet_in_burst: assert property (@(posedge clk) disable iff (rst)
    strobe.inBurst |-> !tick32);

  // R3: the square wave only rises right after a passed fast tick
  a_r3_sq_rise_on_step: assert property (@(posedge clk) disable iff (rst)
    $rose(sq32) |-> $past(strobe.step8k));
endmodule

// File: rtl/cdiv_meas.sv
`timescale 1ns/1ps
module cdiv_meas #(
  parameter int PRE_DIV = 4,
  parameter int MID_DIV = 256,
  parameter int INH_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INH_W-1:0] trimIn,
  output logic             measWave
);
  localparam int BASE    = PRE_DIV * MID_DIV;
  localparam int LEN_MAX = BASE + PRE_DIV * ((1 << INH_W) - 1);
  localparam int CNT_W   = $clog2(LEN_MAX);
  localparam logic [CNT_W-1:0] BASE_LAST = CNT_W'(BASE - 1);
  localparam logic [CNT_W-1:0] HALF      = CNT_W'(BASE / 2);
  localparam logic [CNT_W-1:0] PRE_K     = CNT_W'(PRE_DIV);

  logic [CNT_W-1:0] measCnt;
  logic [INH_W-1:0] measN;
  logic [CNT_W-1:0] lastIdx;

  always_comb begin
    lastIdx  = BASE_LAST + PRE_K * CNT_W'(measN);
    measWave = (measCnt < HALF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      measCnt <= '0;
      measN   <= trimIn;
    end else if (measCnt == lastIdx) begin
      measCnt <= '0;
      measN   <= trimIn;
    end else begin
      measCnt <= measCnt + 1'b1;
    end
  end

  // R8: the high phase lasts more than one clock
  a_r8_high_min: assert property (@(posedge clk) disable iff (rst)
    $rose(measWave) |=> measWave);

  // R8: frame counter stays inside the stretched frame
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    measCnt <= lastIdx);
endmodule

// File: rtl/calib_divider.sv
`timescale 1ns/1ps
module calib_divider
  import cdiv_pkg::*;
#(
  parameter int PRE_DIV     = 4,
  parameter int MID_DIV     = 256,
  parameter int LOW_DIV     = 32,
  parameter int SEC_PER_MIN = 60,
  parameter int INH_W       = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INH_W-1:0] trimCount,
  input  logic             windowSel,
  output logic             tick8k,
  output logic             tick32,
  output logic             tick1,
  output logic             sq32,
  output logic             measWave
);
  cdivStrobe_t strobe;

  cdiv_ctrl #(.PRE_DIV(PRE_DIV), .SEC_PER_MIN(SEC_PER_MIN), .INH_W(INH_W)) u_ctrl (
    .clk(clk), .rst(rst), .trimIn(trimCount), .selIn(windowSel),
    .tick1(tick1), .strobe(strobe)
  );

  cdiv_dp #(.MID_DIV(MID_DIV), .LOW_DIV(LOW_DIV)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .tick8k(tick8k), .tick32(tick32), .tick1(tick1), .sq32(sq32)
  );

  cdiv_meas #(.PRE_DIV(PRE_DIV), .MID_DIV(MID_DIV), .INH_W(INH_W)) u_meas (
    .clk(clk), .rst(rst), .trimIn(trimCount), .measWave(measWave)
  );
endmodule

// File: tb/sim_calib_divider.sv
`timescale 1ns/1ps
module sim_calib_divider;
  localparam int PRE = 4;
  localparam int MID = 8;
  localparam int LOW = 2;
  localparam int SEC = 3;
  localparam int NOM = PRE * MID * LOW;   // 64 clocks per slow tick
  localparam int NV  = 6;

  // stimulus and expected gap after a window end, and window length in slow ticks
  localparam int vN   [NV] = '{0, 1, 5, 127, 127, 64};
  localparam int vSel [NV] = '{0, 0, 1, 0, 1, 1};
  localparam int vGap [NV] = '{64, 68, 84, 572, 572, 320};
  localparam int vSecs[NV] = '{3, 3, 6, 3, 6, 6};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] trimCount = '0;
  logic       windowSel = 1'b0;
  logic       tick8k, tick32, tick1, sq32, measWave;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  calib_divider #(.PRE_DIV(PRE), .MID_DIV(MID), .LOW_DIV(LOW), .SEC_PER_MIN(SEC)) u0 (
    .clk(clk), .rst(rst), .trimCount(trimCount), .windowSel(windowSel),
    .tick8k(tick8k), .tick32(tick32), .tick1(tick1), .sq32(sq32), .measWave(measWave)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reset with n0/sel0, then present n1/sel1 at release and observe
  task automatic runCase(input int n0, input int sel0, input int n1, input int sel1,
                         input int gap1, input int secs1);
    int secs0, nextEnd, curGap, k, prevT, cnt8, measRise, lastRise, sqRise, lastSq;
    bit prevMeas, prevSq;
    secs0 = sel0 ? 2 * SEC : SEC;
    @(negedge clk);
    rst = 1'b1; trimCount = 7'(n0); windowSel = sel0[0];
    @(negedge clk);
    @(negedge clk);
    check(tick8k == 1'b0, "R1 tick8k in reset", int'(tick8k), 0);
    check(tick1 == 1'b0 && tick32 == 1'b0, "R1 ticks in reset", int'(tick1), 0);
    check(sq32 == 1'b0, "R1 sq32 in reset", int'(sq32), 0);
    check(measWave == 1'b1, "R1 measWave in reset", int'(measWave), 1);
    rst = 1'b0; trimCount = 7'(n1); windowSel = sel1[0];
    nextEnd = secs0 - 1; curGap = NOM + PRE * n0;
    k = 0; prevT = 0; cnt8 = 0; measRise = 0; lastRise = 0; sqRise = 0; lastSq = 0;
    prevMeas = 1'b1; prevSq = 1'b0;
    for (int cyc = 1; cyc < 20000 && k < secs0 + 2 * secs1 + 1; cyc++) begin
      @(negedge clk);
      if (tick8k) cnt8++;
      if (tick1) begin
        if (k == 0)
          check(cyc == NOM - 1, "R1 first slow tick", cyc, NOM - 1);
        else if (k - 1 == nextEnd) begin
          check(cyc - prevT == curGap, "R4 R5 R6 R7 trimmed gap", cyc - prevT, curGap);
          nextEnd += secs1; curGap = gap1;
        end else
          check(cyc - prevT == NOM, "R2 R5 nominal gap", cyc - prevT, NOM);
        check(cnt8 == MID * LOW, "R9 fast ticks per slow tick", cnt8, MID * LOW);
        cnt8 = 0; prevT = cyc; k++;
      end
      if (measWave && !prevMeas) begin
        measRise++;
        if (measRise == 1)
          check(cyc == PRE * MID + PRE * n0, "R8 first frame length", cyc, PRE * MID + PRE * n0);
        else if (measRise == 2)
          check(cyc - lastRise == PRE * MID + PRE * n1, "R8 R6 second frame length",
                cyc - lastRise, PRE * MID + PRE * n1);
        lastRise = cyc;
      end
      if (!measWave && prevMeas && measRise >= 1 && measRise <= 2)
        check(cyc - lastRise == PRE * MID / 2, "R8 high phase", cyc - lastRise, PRE * MID / 2);
      if (sq32 && !prevSq) begin
        sqRise++;
        if (sqRise == 1)
          check(cyc == PRE * MID / 2, "R3 first sq32 rise", cyc, PRE * MID / 2);
        else if (sqRise == 2)
          check(cyc - lastSq == PRE * MID, "R3 sq32 period", cyc - lastSq, PRE * MID);
        lastSq = cyc;
      end
      prevMeas = measWave;
      prevSq   = sq32;
    end
    check(k == secs0 + 2 * secs1 + 1, "R5 slow ticks seen", k, secs0 + 2 * secs1 + 1);
  endtask

  initial begin
    for (int i = 0; i < NV; i++)
      runCase(vN[i], vSel[i], vN[i], vSel[i], vGap[i], vSecs[i]);
    // R6: new inputs presented mid-window wait for the next window
    runCase(2, 0, 9, 1, NOM + PRE * 9, 2 * SEC);
    // R7: largest trim after a zero trim window
    runCase(0, 1, 127, 0, NOM + PRE * 127, SEC);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule